// File: doc/BRIEF.md
# Descriptor-Ring Receive DMA Engine

This engine takes a continuous stream of received serial bytes and places them in memory under the control of a ring of linked descriptors. Each descriptor names a chunk of a common receive buffer through a start address and an end ("after") address, and carries the index of the next descriptor, an end-of-list flag and an interrupt flag. The engine fills the current chunk, optionally raises an interrupt, and moves to the descriptor that the next field names. The last descriptor points back to the first, so the chain is a closed ring.

Software holds the engine back by keeping one end-of-list marker in the ring. When the engine arrives at a descriptor that carries the marker, it stops before writing anything into that chunk, reports that it is halted and holds its byte input off with ready low. After each serviced chunk, software moves the marker one place forward by rewriting two descriptors, issues a continue command and acknowledges the interrupt. Software follows the engine's progress by comparing the exposed current-descriptor index with its own next-descriptor index. Descriptors are kept in a small internal table that has a write port. Data leaves through a plain memory write port with byte enables, one or two bytes per beat.

Top module: `rxring_dma`

## Requirements
- R1: After reset, in_ready, halted, irq and mem_we are 0 and cur_desc is 0. The engine stays idle and accepts no byte until a start command arrives.
- R2: A start command loads start_idx into cur_desc on the same clock edge and latches the beat size from cfg_wide. The next cycle reads that descriptor. If the descriptor has no end-of-list marker, in_ready is 1 from the cycle after that, and the first write goes to the descriptor's start address.
- R3: In byte mode (cfg_wide = 0 at start), every byte accepted (in_valid and in_ready high at a clock edge) produces, in the next cycle, a single mem_we pulse. The write address is the current write pointer, mem_wdata[7:0] holds the byte, mem_wdata[15:8] is 0 and mem_be = 2'b01. The pointer then advances by 1.
- R4: In word mode (cfg_wide = 1 at start), the first byte of each pair produces no write. The second byte produces a write at the write pointer with mem_wdata = {second byte, first byte} and mem_be = 2'b11. The pointer then advances by 2.
- R5: When the advanced write pointer equals the descriptor's after address exactly, the chunk is complete. cur_desc takes the descriptor's next index on that edge and the next descriptor is read in the following cycle, so chunks of any length follow one another and the ring wraps through the next fields.
- R6: Completing a chunk whose descriptor has its interrupt flag set raises irq on the same edge as the final write. Completing a chunk whose interrupt flag is clear leaves irq unchanged.
- R7: irq stays 1 until an irq_ack pulse, which clears it on the next edge. An irq_ack in the same cycle as a completion that raises the interrupt leaves irq at 1.
- R8: When the descriptor being read carries the end-of-list marker, the engine writes nothing into its chunk. halted becomes 1 and in_ready stays 0, and no mem_we occurs, until a continue command. This also holds when start points straight at the marked descriptor.
- R9: A continue command while halted makes the engine read the current descriptor again. If software has cleared the marker, filling resumes at that descriptor's start address. If the marker is still set, the engine halts again at the same cur_desc.
- R10: A descriptor write (dw_en with dw_idx and the fields) replaces the whole table entry on the next edge. The engine uses the new contents the next time it reads that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 8 | Received byte |
| in_valid | input | 1 | in_data holds a byte |
| in_ready | output | 1 | Engine accepts a byte this cycle |
| cfg_wide | input | 1 | Beat size latched at start: 0 = 1 byte, 1 = 2 bytes |
| cmd_start | input | 1 | Load the context from descriptor start_idx |
| start_idx | input | IDX_W | First descriptor index |
| cmd_cont | input | 1 | Resume from halt by reading the current descriptor again |
| dw_en | input | 1 | Write one descriptor table entry |
| dw_idx | input | IDX_W | Entry to write |
| dw_base | input | ADDR_W | Chunk start address |
| dw_after | input | ADDR_W | Address just past the chunk |
| dw_next | input | IDX_W | Index of the following descriptor |
| dw_eol | input | 1 | End-of-list marker |
| dw_intr | input | 1 | Interrupt on completion |
| irq_ack | input | 1 | Clear the sticky interrupt |
| irq | output | 1 | Sticky chunk-complete interrupt |
| halted | output | 1 | Stopped on an end-of-list descriptor |
| cur_desc | output | IDX_W | Index of the current descriptor |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_wdata | output | 16 | Write data, lane 0 in bits 7:0 |
| mem_be | output | 2 | Byte-lane enables |

## Verification
A wrong write pointer or a lost half-word shows up at the very next mem_we pulse as a wrong address, data or lane enable, one cycle after the byte that caused it. A wrong next index or a wrong end compare shows up in cur_desc on the edge of the final write of a chunk. It also makes the next write land at a start address the bench does not expect. A wrong marker or halt decision shows up within two cycles as a wrong halted or in_ready, or as a write the bench never predicted. A mishandled interrupt bit shows up in irq on the edge of completion or acknowledge.

// File: rtl/rxring_pkg.sv
`timescale 1ns/1ps
package rxring_pkg;
    localparam int BYTE_W = 8;
    localparam int LANES  = 2;
    localparam int BEAT_W = BYTE_W * LANES;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_RUN   = 2'd2,
        ST_HALT  = 2'd3
    } eng_state_e;
endpackage

// File: rtl/rxring_desc_table.sv
`timescale 1ns/1ps
module rxring_desc_table #(
    parameter int NDESC  = 48,
    parameter int ADDR_W = 16,
    localparam int IDX_W = (NDESC > 1) ? $clog2(NDESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [ADDR_W-1:0] wr_after,
    input  logic [IDX_W-1:0]  wr_next,
    input  logic              wr_eol,
    input  logic              wr_intr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_base,
    output logic [ADDR_W-1:0] rd_after,
    output logic [IDX_W-1:0]  rd_next,
    output logic              rd_eol,
    output logic              rd_intr
);
    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] after;
        logic [IDX_W-1:0]  nxt;
        logic              eol;
        logic              ien;
    } ent_t;

    ent_t tbl_d [NDESC];
    ent_t tbl_q [NDESC];
    ent_t rd_ent;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (int'(wr_idx) < NDESC)) begin
            tbl_d[wr_idx] = '{base: wr_base, after: wr_after, nxt: wr_next,
                              eol: wr_eol, ien: wr_intr};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NDESC; i++) tbl_q[i] <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // Out-of-range indices read as an all-zero entry.
    always_comb begin
        rd_ent = '0;
        if (int'(rd_idx) < NDESC) rd_ent = tbl_q[rd_idx];
    end

    assign rd_base  = rd_ent.base;
    assign rd_after = rd_ent.after;
    assign rd_next  = rd_ent.nxt;
    assign rd_eol   = rd_ent.eol;
    assign rd_intr  = rd_ent.ien;
endmodule

// File: rtl/rxring_pack.sv
`timescale 1ns/1ps
module rxring_pack
    import rxring_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic              wide,
    input  logic [BYTE_W-1:0] din,
    output logic              beat,
    output logic [BEAT_W-1:0] beat_data,
    output logic [LANES-1:0]  beat_be,
    output logic [1:0]        step
);
    typedef struct packed {
        logic              half;
        logic [BYTE_W-1:0] lo;
    } pk_t;

    pk_t pk_d, pk_q;

    always_comb begin
        pk_d = pk_q;
        if (clr) begin
            pk_d.half = 1'b0;
        end else if (take && wide) begin
            if (!pk_q.half) pk_d.lo = din;
            pk_d.half = ~pk_q.half;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    // A beat is complete on every byte in byte mode, on every second byte in word mode.
    assign beat      = take && (!wide || pk_q.half);
    assign beat_data = wide ? {din, pk_q.lo} : {{BYTE_W{1'b0}}, din};
    assign beat_be   = wide ? {LANES{1'b1}} : {{(LANES-1){1'b0}}, 1'b1};
    assign step      = wide ? 2'd2 : 2'd1;
endmodule

// File: rtl/rxring_ctrl.sv
`timescale 1ns/1ps
module rxring_ctrl
    import rxring_pkg::*;
#(
    parameter int NDESC  = 48,
    parameter int ADDR_W = 16,
    localparam int IDX_W = (NDESC > 1) ? $clog2(NDESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              cmd_start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic              cfg_wide,
    input  logic              cmd_cont,
    input  logic              irq_ack,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic [ADDR_W-1:0] rd_base,
    input  logic [ADDR_W-1:0] rd_after,
    input  logic [IDX_W-1:0]  rd_next,
    input  logic              rd_eol,
    input  logic              rd_intr,
    output logic              take,
    output logic              pk_clr,
    output logic              pk_wide,
    input  logic              pk_beat,
    input  logic [BEAT_W-1:0] pk_data,
    input  logic [LANES-1:0]  pk_be,
    input  logic [1:0]        pk_step,
    output logic              irq,
    output logic              halted,
    output logic [IDX_W-1:0]  cur_desc,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BEAT_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_be
);
    typedef struct packed {
        eng_state_e        st;
        logic [IDX_W-1:0]  cur;
        logic [ADDR_W-1:0] wp;
        logic [ADDR_W-1:0] lim;
        logic [IDX_W-1:0]  nxt;
        logic              ien;
        logic              wide;
        logic              irq;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [BEAT_W-1:0] data;
        logic [LANES-1:0]  be;
    } ctx_t;

    ctx_t              ctx_d, ctx_q;
    logic              done;
    logic [ADDR_W-1:0] wp_nx;

    assign in_ready = (ctx_q.st == ST_RUN);
    assign take     = in_valid && in_ready;
    assign pk_clr   = cmd_start;
    assign pk_wide  = ctx_q.wide;
    assign rd_idx   = ctx_q.cur;
    assign wp_nx    = ctx_q.wp + ADDR_W'(pk_step);

    always_comb begin
        ctx_d    = ctx_q;
        ctx_d.we = 1'b0;
        done     = 1'b0;
        case (ctx_q.st)
            ST_FETCH: begin
                // A marked descriptor is never filled: stop before touching it.
                if (rd_eol) begin
                    ctx_d.st = ST_HALT;
                end else begin
                    ctx_d.wp  = rd_base;
                    ctx_d.lim = rd_after;
                    ctx_d.nxt = rd_next;
                    ctx_d.ien = rd_intr;
                    ctx_d.st  = ST_RUN;
                end
            end
            ST_RUN: begin
                if (take && pk_beat) begin
                    ctx_d.we   = 1'b1;
                    ctx_d.addr = ctx_q.wp;
                    ctx_d.data = pk_data;
                    ctx_d.be   = pk_be;
                    ctx_d.wp   = wp_nx;
                    if (wp_nx == ctx_q.lim) begin
                        done      = 1'b1;
                        ctx_d.cur = ctx_q.nxt;
                        ctx_d.st  = ST_FETCH;
                    end
                end
            end
            ST_HALT: begin
                if (cmd_cont) ctx_d.st = ST_FETCH;
            end
            default: ;
        endcase
        if (cmd_start) begin
            ctx_d.st   = ST_FETCH;
            ctx_d.cur  = start_idx;
            ctx_d.wide = cfg_wide;
        end
        // A completion in the acknowledge cycle wins over the clear.
        ctx_d.irq = (ctx_q.irq & ~irq_ack) | (done & ctx_q.ien);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign irq       = ctx_q.irq;
    assign halted    = (ctx_q.st == ST_HALT);
    assign cur_desc  = ctx_q.cur;
    assign mem_we    = ctx_q.we;
    assign mem_addr  = ctx_q.addr;
    assign mem_wdata = ctx_q.data;
    assign mem_be    = ctx_q.be;

    // R3: every write is the result of a byte accepted on the previous edge
    p_write_after_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(in_valid && in_ready));

    // R5: the cursor moves only with a chunk's final write or a start command
    p_cursor_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_desc) |-> (mem_we || $past(cmd_start)));

    // R6: the interrupt rises only together with a chunk's final write
    p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> mem_we);

    // R7: without an acknowledge the interrupt stays set
    p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && !$past(irq_ack)) |-> irq);

    // R8: halting is caused by reading a marked descriptor
    p_halt_on_eol_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halted) |-> $past(rd_eol));

    // R8: nothing is written while halted
    p_no_write_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);
endmodule

// File: rtl/rxring_dma.sv
`timescale 1ns/1ps
module rxring_dma
    import rxring_pkg::*;
#(
    parameter int NDESC  = 48,
    parameter int ADDR_W = 16,
    localparam int IDX_W = (NDESC > 1) ? $clog2(NDESC) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              cfg_wide,
    input  logic              cmd_start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic              cmd_cont,
    input  logic              dw_en,
    input  logic [IDX_W-1:0]  dw_idx,
    input  logic [ADDR_W-1:0] dw_base,
    input  logic [ADDR_W-1:0] dw_after,
    input  logic [IDX_W-1:0]  dw_next,
    input  logic              dw_eol,
    input  logic              dw_intr,
    input  logic              irq_ack,
    output logic              irq,
    output logic              halted,
    output logic [IDX_W-1:0]  cur_desc,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BEAT_W-1:0] mem_wdata,
    output logic [LANES-1:0]  mem_be
);
    logic [IDX_W-1:0]  rd_idx;
    logic [ADDR_W-1:0] rd_base, rd_after;
    logic [IDX_W-1:0]  rd_next;
    logic              rd_eol, rd_intr;
    logic              take, pk_clr, pk_wide, pk_beat;
    logic [BEAT_W-1:0] pk_data;
    logic [LANES-1:0]  pk_be;
    logic [1:0]        pk_step;

    rxring_desc_table #(.NDESC(NDESC), .ADDR_W(ADDR_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .wr_en(dw_en), .wr_idx(dw_idx), .wr_base(dw_base), .wr_after(dw_after),
        .wr_next(dw_next), .wr_eol(dw_eol), .wr_intr(dw_intr),
        .rd_idx(rd_idx), .rd_base(rd_base), .rd_after(rd_after),
        .rd_next(rd_next), .rd_eol(rd_eol), .rd_intr(rd_intr)
    );

    rxring_pack u_pack (
        .clk(clk), .rst_n(rst_n), .clr(pk_clr), .take(take), .wide(pk_wide),
        .din(in_data), .beat(pk_beat), .beat_data(pk_data), .beat_be(pk_be),
        .step(pk_step)
    );

    rxring_ctrl #(.NDESC(NDESC), .ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .cmd_start(cmd_start), .start_idx(start_idx), .cfg_wide(cfg_wide),
        .cmd_cont(cmd_cont), .irq_ack(irq_ack),
        .rd_idx(rd_idx), .rd_base(rd_base), .rd_after(rd_after),
        .rd_next(rd_next), .rd_eol(rd_eol), .rd_intr(rd_intr),
        .take(take), .pk_clr(pk_clr), .pk_wide(pk_wide), .pk_beat(pk_beat),
        .pk_data(pk_data), .pk_be(pk_be), .pk_step(pk_step),
        .irq(irq), .halted(halted), .cur_desc(cur_desc),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be)
    );
endmodule

// File: tb/rxring_dma_bench.sv
`timescale 1ns/1ps
module rxring_dma_bench;
    localparam int ND = 4;
    localparam int AW = 12;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          cfg_wide = 1'b0;
    logic          cmd_start = 1'b0;
    logic [IW-1:0] start_idx = '0;
    logic          cmd_cont = 1'b0;
    logic          dw_en = 1'b0;
    logic [IW-1:0] dw_idx = '0;
    logic [AW-1:0] dw_base = '0, dw_after = '0;
    logic [IW-1:0] dw_next = '0;
    logic          dw_eol = 1'b0, dw_intr = 1'b0;
    logic          irq_ack = 1'b0;
    logic          irq, halted, mem_we;
    logic [IW-1:0] cur_desc;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_wdata;
    logic [1:0]    mem_be;

    always #2.5 clk = ~clk;

    rxring_dma #(.NDESC(ND), .ADDR_W(AW)) u_rxring_dma (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .cfg_wide(cfg_wide), .cmd_start(cmd_start),
        .start_idx(start_idx), .cmd_cont(cmd_cont), .dw_en(dw_en), .dw_idx(dw_idx),
        .dw_base(dw_base), .dw_after(dw_after), .dw_next(dw_next), .dw_eol(dw_eol),
        .dw_intr(dw_intr), .irq_ack(irq_ack), .irq(irq), .halted(halted),
        .cur_desc(cur_desc), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bench copy of the descriptor table and the expected engine context.
    logic [AW-1:0] t_base [ND];
    logic [AW-1:0] t_after[ND];
    logic [IW-1:0] t_next [ND];
    bit            t_eol  [ND];
    bit            t_intr [ND];

    logic [IW-1:0] m_cur = '0, m_next = '0;
    logic [AW-1:0] m_wp = '0, m_end = '0;
    logic [7:0]    m_lo = '0;
    bit            m_intr, m_wide, m_half, m_halt, m_irq;

    // Queue of expected memory writes.
    logic [AW-1:0] ea [1024];
    logic [15:0]   ed [1024];
    logic [1:0]    eb [1024];
    int ew = 0;
    int er = 0;

    function automatic void push_exp(input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] b);
        ea[ew % 1024] = a;
        ed[ew % 1024] = d;
        eb[ew % 1024] = b;
        ew++;
    endfunction

    function automatic void model_fetch();
        if (t_eol[m_cur]) begin
            m_halt = 1'b1;
        end else begin
            m_halt = 1'b0;
            m_wp   = t_base[m_cur];
            m_end  = t_after[m_cur];
            m_next = t_next[m_cur];
            m_intr = t_intr[m_cur];
        end
    endfunction

    function automatic void model_take(input logic [7:0] b, input bit ack);
        bit adv = 1'b0;
        bit set = 1'b0;
        if (!m_wide) begin
            push_exp(m_wp, {8'h00, b}, 2'b01);
            m_wp = m_wp + 1;
            adv  = 1'b1;
        end else if (!m_half) begin
            m_lo   = b;
            m_half = 1'b1;
        end else begin
            push_exp(m_wp, {b, m_lo}, 2'b11);
            m_wp   = m_wp + 2;
            m_half = 1'b0;
            adv    = 1'b1;
        end
        if (adv && (m_wp == m_end)) begin
            set   = m_intr;
            m_cur = m_next;
            model_fetch();
        end
        m_irq = (m_irq & ~ack) | set;
    endfunction

    // Every write on the port must match the next expected write.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (er == ew) begin
                chk(1'b0, "R8 unexpected write addr", longint'(mem_addr), 0);
            end else begin
                chk(mem_addr == ea[er % 1024], "R3/R4/R5 write address", longint'(mem_addr), longint'(ea[er % 1024]));
                chk(mem_wdata == ed[er % 1024], "R3/R4 write data", longint'(mem_wdata), longint'(ed[er % 1024]));
                chk(mem_be == eb[er % 1024], "R3/R4 byte enables", longint'(mem_be), longint'(eb[er % 1024]));
                er++;
            end
        end
    end

    // All tasks start and end just after a falling edge.
    task automatic desc_wr(input int i, input logic [AW-1:0] b, input logic [AW-1:0] a,
                           input int nx, input bit e, input bit ie);
        dw_en = 1'b1; dw_idx = IW'(i); dw_base = b; dw_after = a;
        dw_next = IW'(nx); dw_eol = e; dw_intr = ie;
        @(negedge clk);
        dw_en = 1'b0;
        t_base[i] = b; t_after[i] = a; t_next[i] = IW'(nx); t_eol[i] = e; t_intr[i] = ie;
    endtask

    task automatic do_start(input int idx, input bit w);
        cmd_start = 1'b1; start_idx = IW'(idx); cfg_wide = w;
        @(posedge clk); #1;
        m_cur = IW'(idx); m_wide = w; m_half = 1'b0;
        model_fetch();
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic do_cont();
        cmd_cont = 1'b1;
        @(posedge clk); #1;
        if (m_halt) model_fetch();
        @(negedge clk);
        cmd_cont = 1'b0;
    endtask

    task automatic do_ack();
        irq_ack = 1'b1;
        @(posedge clk); #1;
        m_irq = 1'b0;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b, input bit ack, input int gap);
        in_valid = 1'b1; in_data = b;
        while (!in_ready) @(negedge clk);
        irq_ack = ack;
        @(posedge clk); #1;
        model_take(b, ack);
        @(negedge clk);
        in_valid = 1'b0; irq_ack = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic push_n(input int n, input bit rand_ack);
        for (int k = 0; k < n; k++) begin
            push_byte(8'($urandom), rand_ack && ($urandom_range(0, 3) == 0), $urandom_range(0, 2));
        end
    endtask

    task automatic settle(input string tag);
        repeat (3) @(negedge clk);
        chk(halted == m_halt, {tag, " halted"}, longint'(halted), longint'(m_halt));
        chk(cur_desc == m_cur, {tag, " cur_desc"}, longint'(cur_desc), longint'(m_cur));
        chk(irq == m_irq, {tag, " irq"}, longint'(irq), longint'(m_irq));
        chk(in_ready == !m_halt, {tag, " in_ready"}, longint'(in_ready), longint'(!m_halt));
    endtask

    function automatic int chunk_bytes(input int s, input int e);
        int tot = 0;
        int i = s;
        while (i != e) begin
            tot += int'(t_after[i] - t_base[i]);
            i = int'(t_next[i]);
        end
        return tot;
    endfunction

    initial begin
        #500000;
        n_err++;
        $display("FAIL watchdog R1..R10 not finished actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < ND; i++) begin
            t_base[i] = '0; t_after[i] = '0; t_next[i] = '0; t_eol[i] = 0; t_intr[i] = 0;
        end
        m_intr = 0; m_wide = 0; m_half = 0; m_halt = 0; m_irq = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(in_ready == 1'b0, "R1 in_ready", longint'(in_ready), 0);
        chk(halted == 1'b0, "R1 halted", longint'(halted), 0);
        chk(irq == 1'b0, "R1 irq", longint'(irq), 0);
        chk(mem_we == 1'b0, "R1 mem_we", longint'(mem_we), 0);
        chk(cur_desc == '0, "R1 cur_desc", longint'(cur_desc), 0);
        in_valid = 1'b1;
        repeat (4) @(negedge clk);
        chk(in_ready == 1'b0, "R1 idle ignores bytes", longint'(in_ready), 0);
        in_valid = 1'b0;

        // R10: program a ring with uneven chunks, marker on entry 3
        desc_wr(0, 12'h100, 12'h108, 1, 0, 1);
        desc_wr(1, 12'h200, 12'h205, 2, 0, 0);
        desc_wr(2, 12'h300, 12'h306, 3, 0, 1);
        desc_wr(3, 12'h400, 12'h408, 0, 1, 1);

        // R2: start in byte mode at entry 0
        do_start(0, 1'b0);
        chk(cur_desc == 2'd0, "R2 cur_desc after start", longint'(cur_desc), 0);
        @(negedge clk);
        chk(in_ready == 1'b1, "R2 ready after fetch", longint'(in_ready), 1);

        push_n(8, 0);                     // R3, R5: chunk 0 exact length 8
        settle("R6 chunk with interrupt");
        do_ack();
        chk(irq == 1'b0, "R7 ack clears irq", longint'(irq), 0);
        push_n(5, 0);                     // R5: 5-byte chunk, R6: intr flag clear
        settle("R6 chunk without interrupt");
        push_n(6, 0);
        settle("R8 halt at marker");
        chk(cur_desc == 2'd3, "R8 halted cur_desc", longint'(cur_desc), 3);

        // R8: bytes offered while halted are held off
        in_valid = 1'b1; in_data = 8'hA5;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (k == 9) chk(in_ready == 1'b0, "R8 ready low while halted", longint'(in_ready), 0);
        end
        in_valid = 1'b0;

        // R9: continue with marker still present halts again
        do_cont();
        settle("R9 continue with marker kept");

        // R9, R10: move the marker and continue; ack on the final byte (R7)
        desc_wr(3, 12'h400, 12'h408, 0, 0, 1);
        desc_wr(0, 12'h100, 12'h108, 1, 1, 1);
        do_cont();
        push_n(7, 0);
        push_byte(8'h3C, 1'b1, 0);
        chk(irq == 1'b1, "R7 ack same cycle as completion keeps irq", longint'(irq), 1);
        settle("R5 ring wrap to entry 0");
        do_ack();

        // R4: word mode from entry 1
        desc_wr(0, 12'h100, 12'h108, 1, 0, 1);
        desc_wr(1, 12'h220, 12'h228, 2, 0, 0);
        desc_wr(2, 12'h320, 12'h32A, 3, 0, 1);
        desc_wr(3, 12'h420, 12'h428, 0, 1, 1);
        do_start(1, 1'b1);
        push_n(18, 0);
        settle("R4 word mode halt");

        // R8: start directly on the marked entry
        do_start(3, 1'b0);
        settle("R8 start on marker");

        // Random rounds
        for (int r = 0; r < 6; r++) begin
            int e = $urandom_range(0, ND - 1);
            int s = (e + 1 + $urandom_range(0, ND - 2)) % ND;
            bit w = 1'($urandom_range(0, 1));
            if (irq) do_ack();
            for (int i = 0; i < ND; i++) begin
                logic [AW-1:0] b = AW'((i + 1) * 256 + r * 16);
                int len = 2 * $urandom_range(1, 6);
                desc_wr(i, b, b + AW'(len), (i + 1) % ND, (i == e), 1'($urandom_range(0, 1)));
            end
            do_start(s, w);
            push_n(chunk_bytes(s, e), 1);
            settle("R5/R6 random ring round");
        end

        chk(er == ew, "R3 all expected writes seen", longint'(er), longint'(ew));
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule